// File: doc/BRIEF.md
# Bang-Bang Charge-Pump Pulse Gater

This block drives the two complementary clock phases of a switched-capacitor dynamic supply. Each complete pump pulse (phase A high, a dead gap, phase B high, a second dead gap) moves the supply output by one fixed step. The sign of the step follows a source/sink select. Feedback is a single comparator bit. It does not set the pulse rate. It only passes or blocks whole pulses, so the loop is a bang-bang controller. When no pulse is passed, both phases sit low and the output voltage is held.

The comparator bit is sampled once per evaluation window of `WIN` fast clocks (five by default, matching a 125 MHz pump clock with a 25 MHz error sampler). The sample is taken on the last cycle of each window, and the gate decision and pump direction stay fixed until the next window. The decision depends on the mode:

- SUPPLY: the bit says whether the current-source node is below its set point, and the pump always sources.
- TRACK: the bit compares the supply output with the electrode, and the direction comes from the stimulus-phase sequencer.
- IDLE: stops all pumping at once and selects sink.

The phase FSM has states REST, PH_A, GAP_AB, PH_B and GAP_BA. Its transitions are:

- REST→PH_A when the gate is open.
- PH_A→GAP_AB after `PH_HIGH` cycles.
- GAP_AB→PH_B after the dead time.
- PH_B→GAP_BA after `PH_HIGH` cycles.
- GAP_BA→PH_A if the gate is still open, or GAP_BA→REST if it is not.
- Any state→REST when the mode is IDLE.

Top module: `pump_pulse_gater`

## Requirements
- R1: While reset is held and in the first cycle after it is released, both phases and `pump_src` are 0 (sink).
- R2: Mode code 2'b00 (IDLE) or 2'b11 (reserved, treated as IDLE) drives both phases low and `pump_src` to 0 one clock later, even in the middle of a pulse.
- R3: In mode 2'b10 (SUPPLY), `pump_src` is 1, pulses are passed in windows whose sampled error bit is 1, and no new pulse starts in windows whose sampled error bit is 0.
- R4: When no pulses are passed, both phases are held static low.
- R5: In mode 2'b01 (TRACK), `pump_src` equals `dir_src`, and pulses are passed only in windows whose sampled error bit equals `dir_src`.
- R6: A pulse is phase A high for `PH_HIGH` cycles, then a gap, then phase B high for `PH_HIGH` cycles, then a gap. A pulse that has begun always completes its B phase unless IDLE intervenes.
- R7: Between the fall of either phase and the next rise of the other, both phases are low for exactly max(1, `dead_len`) cycles.
- R8: `phi_a` and `phi_b` are never high in the same cycle.
- R9: The error bit is sampled only in the last cycle of each `WIN`-cycle window, with windows counted from the first cycle after reset. Its value in other cycles has no effect, and the gate decision and `pump_src` change only at window boundaries or on IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast pump clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 00 IDLE, 01 TRACK, 10 SUPPLY, 11 treated as IDLE |
| dir_src | input | 1 | Direction from phase sequencer: 1 source, 0 sink |
| err_bit | input | 1 | Comparator decision bit |
| dead_len | input | DT_W | Dead time in cycles (0 acts as 1) |
| phi_a | output | 1 | Pump phase A |
| phi_b | output | 1 | Pump phase B, non-overlapping with A |
| pump_src | output | 1 | Pump direction select: 1 source, 0 sink |

## Verification
The bench holds the error bit high in every cycle of several windows except the sampling cycle. A design that samples at the wrong point, or samples continuously, would pump when it should stay silent. It also drops the error bit in the middle of a pulse train and checks that the counts of phase A and phase B rises match, which catches a gater that truncates a pulse after phase A. Dead times of 0 and 3 are measured as the number of cycles in which both phases are low. An unclamped zero would let the phases touch, and an off-by-one timer would show up as a gap of 2 or 4. An IDLE request in the middle of a pulse must clear both phases and the direction select within one clock, and the reserved mode code must behave the same way.

// File: rtl/pg_pkg.sv
package pg_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'b00,
        MODE_TRACK  = 2'b01,
        MODE_SUPPLY = 2'b10,
        MODE_RSVD   = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_REST,
        ST_PH_A,
        ST_GAP_AB,
        ST_PH_B,
        ST_GAP_BA
    } ph_state_e;

    // Gate rule: SUPPLY passes on a low node (err=1); TRACK passes when
    // the error matches the requested direction; anything else blocks.
    function automatic logic pass_pulse(mode_e m, logic dir, logic err);
        logic r;
        r = 1'b0;
        unique case (m)
            MODE_SUPPLY: r = err;
            MODE_TRACK:  r = (err == dir);
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic is_idle(mode_e m);
        return (m == MODE_IDLE) || (m == MODE_RSVD);
    endfunction

endpackage

// File: rtl/pg_window.sv
module pg_window
    import pg_pkg::*;
#(
    parameter int WIN = 5
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  dir_src,
    input  logic  err_bit,
    output logic  gate_q,
    output logic  src_q,
    output logic  win_last
);
    localparam int CW = (WIN > 2) ? $clog2(WIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    logic [CW-1:0] cnt;
    logic          idle;

    assign idle     = is_idle(mode);
    assign win_last = (cnt == LAST);

    // window position counter, aligned to reset release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (win_last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // decision register: one sample per window, IDLE overrides at once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            src_q  <= 1'b0;
        end else if (idle) begin
            gate_q <= 1'b0;
            src_q  <= 1'b0;
        end else if (win_last) begin
            gate_q <= pass_pulse(mode, dir_src, err_bit);
            src_q  <= (mode == MODE_SUPPLY) ? 1'b1 : dir_src;
        end
    end

    // R9
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_last && !idle) |=> ($stable(gate_q) && $stable(src_q)));

    // R3
    supply_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_last && mode == MODE_SUPPLY) |=> src_q);

    // R2
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> (!gate_q && !src_q));

endmodule

// File: rtl/pg_phase_fsm.sv
module pg_phase_fsm
    import pg_pkg::*;
#(
    parameter int PH_HIGH = 1,
    parameter int DT_W    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idle,
    input  logic            gate,
    input  logic [DT_W-1:0] dead_len,
    output logic            phi_a,
    output logic            phi_b
);
    localparam int HW = (PH_HIGH > 1) ? $clog2(PH_HIGH + 1) : 1;
    localparam int TW = (DT_W > HW) ? DT_W : HW;
    localparam logic [TW-1:0] HI_LOAD = TW'(PH_HIGH - 1);

    ph_state_e       state, nxt_state;
    logic [TW-1:0]   tmr, nxt_tmr;
    logic [DT_W-1:0] dead_m1;
    logic [TW-1:0]   dead_load;

    // zero dead time is clamped to one cycle
    assign dead_m1   = (dead_len == '0) ? '0 : (dead_len - DT_W'(1));
    assign dead_load = TW'(dead_m1);

    always_comb begin
        nxt_state = state;
        nxt_tmr   = tmr;
        unique case (state)
            ST_REST: begin
                if (gate) begin
                    nxt_state = ST_PH_A;
                    nxt_tmr   = HI_LOAD;
                end
            end
            ST_PH_A: begin
                if (tmr == '0) begin
                    nxt_state = ST_GAP_AB;
                    nxt_tmr   = dead_load;
                end else begin
                    nxt_tmr = tmr - TW'(1);
                end
            end
            ST_GAP_AB: begin
                if (tmr == '0) begin
                    nxt_state = ST_PH_B;
                    nxt_tmr   = HI_LOAD;
                end else begin
                    nxt_tmr = tmr - TW'(1);
                end
            end
            ST_PH_B: begin
                if (tmr == '0) begin
                    nxt_state = ST_GAP_BA;
                    nxt_tmr   = dead_load;
                end else begin
                    nxt_tmr = tmr - TW'(1);
                end
            end
            ST_GAP_BA: begin
                if (tmr == '0) begin
                    if (gate) begin
                        nxt_state = ST_PH_A;
                        nxt_tmr   = HI_LOAD;
                    end else begin
                        nxt_state = ST_REST;
                        nxt_tmr   = '0;
                    end
                end else begin
                    nxt_tmr = tmr - TW'(1);
                end
            end
            default: begin
                nxt_state = ST_REST;
                nxt_tmr   = '0;
            end
        endcase
        if (idle) begin
            nxt_state = ST_REST;
            nxt_tmr   = '0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_REST;
            tmr   <= '0;
        end else begin
            state <= nxt_state;
            tmr   <= nxt_tmr;
        end
    end

    // registered phase outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phi_a <= 1'b0;
            phi_b <= 1'b0;
        end else begin
            phi_a <= (nxt_state == ST_PH_A);
            phi_b <= (nxt_state == ST_PH_B);
        end
    end

    // alternation tracker used by the checks below
    logic last_a;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_a <= 1'b0;
        end else if (idle) begin
            last_a <= 1'b0;
        end else if (phi_a) begin
            last_a <= 1'b1;
        end else if (phi_b) begin
            last_a <= 1'b0;
        end
    end

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(phi_a && phi_b));

    // R7
    gap_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phi_a) |-> !phi_b);

    // R7
    gap_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phi_b) |-> !phi_a);

    // R6
    b_after_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi_b) |-> last_a);

    // R6
    a_after_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi_a) |-> !last_a);

    // R3
    start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi_a) |-> $past(gate));

    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> (!phi_a && !phi_b));

endmodule

// File: rtl/pump_pulse_gater.sv
module pump_pulse_gater
    import pg_pkg::*;
#(
    parameter int WIN     = 5,
    parameter int PH_HIGH = 1,
    parameter int DT_W    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_sel,
    input  logic            dir_src,
    input  logic            err_bit,
    input  logic [DT_W-1:0] dead_len,
    output logic            phi_a,
    output logic            phi_b,
    output logic            pump_src
);
    mode_e mode;
    logic  gate_q;
    logic  src_q;
    logic  win_last;
    logic  idle;

    assign mode = mode_e'(mode_sel);
    assign idle = is_idle(mode);

    pg_window #(.WIN(WIN)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .dir_src  (dir_src),
        .err_bit  (err_bit),
        .gate_q   (gate_q),
        .src_q    (src_q),
        .win_last (win_last)
    );

    pg_phase_fsm #(.PH_HIGH(PH_HIGH), .DT_W(DT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle     (idle),
        .gate     (gate_q),
        .dead_len (dead_len),
        .phi_a    (phi_a),
        .phi_b    (phi_b)
    );

    assign pump_src = src_q;

    // R2
    idle_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> (!pump_src && !phi_a && !phi_b));

    // R9
    src_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_last && !idle) |=> $stable(pump_src));

endmodule

// File: tb/sim_pump_pulse_gater.sv
`timescale 1ns/1ps
module sim_pump_pulse_gater;
    localparam int WIN = 5;
    localparam int PH  = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       dir_src = 1'b0;
    logic       err_bit = 1'b0;
    logic [3:0] dead_len = 4'd1;
    logic       phi_a, phi_b, pump_src;

    always #2.5 clk = ~clk;

    pump_pulse_gater #(.WIN(WIN), .PH_HIGH(PH), .DT_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dir_src(dir_src),
        .err_bit(err_bit), .dead_len(dead_len),
        .phi_a(phi_a), .phi_b(phi_b), .pump_src(pump_src)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int cyc = 0;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // monitor statistics, sampled on the falling edge
    int  rises_a, rises_b, overlap, min_gap, max_gap, bad_width, gaps_seen;
    int  low_run, hi_a, hi_b;
    bit  have_fall, seen_ra, seen_rb;
    logic pa = 0, pb = 0;

    always @(negedge clk) begin
        logic ra, rb, fa, fb;
        ra = phi_a & ~pa; rb = phi_b & ~pb;
        fa = ~phi_a & pa; fb = ~phi_b & pb;
        if (phi_a && phi_b) overlap++;
        if (ra) begin rises_a++; seen_ra = 1; end
        if (rb) begin rises_b++; seen_rb = 1; end
        if ((ra || rb) && have_fall) begin
            gaps_seen++;
            if (low_run < min_gap) min_gap = low_run;
            if (low_run > max_gap) max_gap = low_run;
        end
        if (fa || fb) begin
            have_fall = 1;
            low_run = (!phi_a && !phi_b) ? 1 : 0;
        end else if (!phi_a && !phi_b) begin
            low_run++;
        end
        if (ra || rb) have_fall = 0;
        if (phi_a) hi_a++;
        if (fa) begin if (seen_ra && hi_a != PH) bad_width++; hi_a = 0; end
        if (phi_b) hi_b++;
        if (fb) begin if (seen_rb && hi_b != PH) bad_width++; hi_b = 0; end
        pa = phi_a; pb = phi_b;
    end

    task automatic clear_stats();
        rises_a = 0; rises_b = 0; overlap = 0; bad_width = 0; gaps_seen = 0;
        min_gap = 1000; max_gap = 0; low_run = 0; hi_a = 0; hi_b = 0;
        have_fall = 0; seen_ra = 0; seen_rb = 0;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #0.5;
    endtask

    // wait until the negedge period whose window position is p
    task automatic at_pos(input int p);
        @(negedge clk);
        while ((cyc % WIN) != p) @(negedge clk);
        #0.5;
    endtask

    task automatic t_reset();
        step(3);
        check(phi_a == 0 && phi_b == 0, "R1 phases in reset", {phi_a, phi_b}, 0);
        check(pump_src == 0, "R1 pump_src in reset", pump_src, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(phi_a == 0 && phi_b == 0 && pump_src == 0, "R1 after release",
              {phi_a, phi_b, pump_src}, 0);
    endtask

    task automatic t_idle();
        mode_sel = 2'b00; err_bit = 1; dir_src = 1;
        step(2); clear_stats(); step(40);
        check(rises_a == 0 && rises_b == 0, "R2 idle pulses", rises_a + rises_b, 0);
        check(pump_src == 0, "R2 idle sink", pump_src, 0);
        mode_sel = 2'b11; step(2); clear_stats(); step(40);
        check(rises_a == 0 && pump_src == 0, "R2 reserved code", rises_a + pump_src, 0);
    endtask

    task automatic t_supply();
        dead_len = 4'd1; mode_sel = 2'b10; err_bit = 1;
        step(12); clear_stats(); step(60);
        check(rises_a >= 10, "R3 supply passes", rises_a, 15);
        check(pump_src == 1, "R3 supply source", pump_src, 1);
        check(overlap == 0, "R8 overlap", overlap, 0);
        check(bad_width == 0, "R6 phase width", bad_width, 0);
        check(min_gap == 1 && max_gap == 1, "R7 dead one", min_gap * 10 + max_gap, 11);
        // drop the error mid-train: every started pulse completes
        clear_stats(); step(3); err_bit = 0; step(30);
        check(rises_a == rises_b, "R6 complete pulses", rises_b, rises_a);
        clear_stats(); step(40);
        check(rises_a == 0 && rises_b == 0, "R3 supply blocked", rises_a, 0);
        check(phi_a == 0 && phi_b == 0, "R4 held static low", {phi_a, phi_b}, 0);
    endtask

    task automatic t_track();
        mode_sel = 2'b01; dir_src = 1; err_bit = 1;
        step(12); clear_stats(); step(40);
        check(rises_a >= 5 && pump_src == 1, "R5 track source pass", rises_a, 10);
        err_bit = 0; step(20); clear_stats(); step(40);
        check(rises_a == 0, "R5 track source block", rises_a, 0);
        dir_src = 0; err_bit = 0; step(12); clear_stats(); step(40);
        check(rises_a >= 5 && pump_src == 0, "R5 track sink pass", rises_a, 10);
        err_bit = 1; step(20); clear_stats(); step(40);
        check(rises_a == 0 && pump_src == 0, "R5 track sink block", rises_a, 0);
    endtask

    task automatic t_dead();
        mode_sel = 2'b10; err_bit = 0; step(20);
        dead_len = 4'd3; err_bit = 1; step(15); clear_stats(); step(60);
        check(min_gap == 3 && max_gap == 3, "R7 dead three", min_gap * 10 + max_gap, 33);
        check(overlap == 0, "R8 overlap dead three", overlap, 0);
        err_bit = 0; step(25);
        dead_len = 4'd0; err_bit = 1; step(15); clear_stats(); step(60);
        check(gaps_seen > 0 && min_gap == 1 && max_gap == 1, "R7 dead zero clamp",
              min_gap * 10 + max_gap, 11);
        err_bit = 0; dead_len = 4'd1; step(25);
    endtask

    task automatic t_window();
        mode_sel = 2'b10; err_bit = 0; step(20);
        clear_stats();
        for (int w = 0; w < 6; w++) begin
            at_pos(0); err_bit = 1;
            at_pos(4); err_bit = 0;
        end
        step(10);
        check(rises_a == 0, "R9 off-sample ignored", rises_a, 0);
        clear_stats();
        at_pos(4); err_bit = 1;
        step(1); err_bit = 0;
        step(15);
        check(rises_a >= 1 && rises_a == rises_b, "R9 sampled cycle", rises_a, 2);
    endtask

    task automatic t_abort();
        mode_sel = 2'b10; err_bit = 1; step(20);
        while (!phi_a) step(1);
        mode_sel = 2'b00;
        step(1);
        check(phi_a == 0 && phi_b == 0 && pump_src == 0, "R2 idle abort",
              {phi_a, phi_b, pump_src}, 0);
        err_bit = 0;
    endtask

    initial begin
        clear_stats();
        t_reset();
        t_idle();
        t_supply();
        t_track();
        t_dead();
        t_window();
        t_abort();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule